// File: doc/BRIEF.md
# Power-up reset sequencer

This block keeps a small processor core in reset after the supply comes up and lets it go in a fixed order. While the power-on pulse is high it samples a 14-bit configuration word. From that word it decodes the oscillator mode, whether the watchdog runs, whether the power-up delay runs and whether brown-out detection may reset the core. The enable bits follow a mixed polarity: the delay bit is active-low, while the watchdog and brown-out bits are active-high. When the pulse ends the block counts a power-up delay on a slow RC tick strobe. It then counts an oscillator settle period on the oscillator clock, and only after that does it release the core reset.

Besides the power-on pulse, the core can be reset by a brown-out level, by an active-low external pin, or by a watchdog timeout. After a brown-out the full sequence runs again. After the external pin is released the core restarts at once if it had already booted. A one-hot status vector records which of the four sources caused the most recent reset. The next power-on sets it back to the power-on cause.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is high from the next clock edge and `rst_cause` reads the power-on code. The configuration word is sampled at each of those edges.
- R2: `wdt_en` equals configuration bit 2 as sampled at power-on. It changes at no other time.
- R3: `osc_mode` equals configuration bits 1:0 as sampled at power-on. The codes are 00 low-power crystal, 01 standard crystal, 10 high-speed crystal and 11 RC.
- R4: The power-up delay runs when configuration bit 3 is 0, or when configuration bit 6 is 1 (whatever bit 3 holds). While it runs, `core_rst` stays high for `PWRT_TICKS` pulses of `rc_tick`.
- R5: When bit 3 is 1 and bit 6 is 0 there is no power-up delay. In RC mode `core_rst` then falls one clock after `por_pulse` falls.
- R6: After the delay, in the three crystal modes, `core_rst` stays high for a further `OST_CYCLES` clocks. In RC mode this settle count is skipped.
- R7: With bit 6 at 1, a high `bod_level` sets `core_rst` on the next edge and sets the cause to brown-out. Reset holds while the level stays high, and the full delay and settle sequence runs once it falls. With bit 6 at 0, `bod_level` has no effect.
- R8: A low `ext_rst_n` sets `core_rst` on the next edge and sets the cause to external. On release, a core that had finished booting restarts one clock later. If boot was still in progress, the full sequence restarts instead.
- R9: When `wdt_en` is 1 and the core is running, a high `wdt_timeout` gives exactly one clock of `core_rst` and sets the cause to watchdog. When `wdt_en` is 0, `wdt_timeout` has no effect.
- R10: `rst_cause` is one-hot. Bit 0 marks power-on, bit 1 brown-out, bit 2 external pin and bit 3 watchdog.
- R11: When sources coincide, power-on wins over brown-out, brown-out over the external pin, and the external pin over the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state changes on its rising edge |
| por_pulse | input | 1 | Power-on pulse, active high, synchronous |
| cfg_word | input | CFG_BITS | Configuration word, sampled while `por_pulse` is high |
| bod_level | input | 1 | Brown-out detector level, high while supply is low |
| ext_rst_n | input | 1 | External reset pin, active low |
| rc_tick | input | 1 | One-cycle strobe from the slow RC oscillator |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| core_rst | output | 1 | Core reset, active high |
| wdt_en | output | 1 | Watchdog enabled by configuration |
| osc_mode | output | 2 | Decoded oscillator mode |
| rst_cause | output | 4 | One-hot cause of the latest reset |

## Verification
The properties assume that every input is already synchronous to `clk` and that `por_pulse` is high from the very first edge, so that all state is defined. They also assume that `cfg_word` is stable for the last two edges of any power-on pulse. The stimulus changes inputs only on the falling clock edge. It holds the power-on pulse for at least two cycles with the configuration word already in place, and it drives `rc_tick` as a strict single-cycle strobe every fourth clock.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

   // configuration word field positions (decoded by the sequencer)
   localparam int CFG_OSC_LSB   = 0;
   localparam int CFG_WDT_BIT   = 2;
   localparam int CFG_DLY_N_BIT = 3;
   localparam int CFG_BOR_BIT   = 6;

   // reset-cause vector
   localparam int CAUSE_W = 4;
   localparam logic [CAUSE_W-1:0] CAUSE_POR_V = 4'b0001;
   localparam logic [CAUSE_W-1:0] CAUSE_BOR_V = 4'b0010;
   localparam logic [CAUSE_W-1:0] CAUSE_EXT_V = 4'b0100;
   localparam logic [CAUSE_W-1:0] CAUSE_WDT_V = 4'b1000;

   typedef enum logic [1:0] {
      OSC_LP = 2'b00,
      OSC_XT = 2'b01,
      OSC_HS = 2'b10,
      OSC_RC = 2'b11
   } osc_mode_e;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_BROWN = 3'd1,
      ST_PIN   = 3'd2,
      ST_DELAY = 3'd3,
      ST_OSC   = 3'd4,
      ST_RUN   = 3'd5,
      ST_WDOG  = 3'd6
   } seq_state_e;

   typedef struct packed {
      osc_mode_e osc;
      logic      wdt_en;
      logic      dly_en;
      logic      bor_en;
   } cfg_dec_t;

endpackage

// File: rtl/pwrup_cfg_latch.sv
module pwrup_cfg_latch
   import pwrup_seq_pkg::*;
#(
   parameter int CFG_BITS = 14
) (
   input  logic                clk,
   input  logic                capture,
   input  logic [CFG_BITS-1:0] cfg_word,
   output cfg_dec_t            dec
);

   logic [CFG_BITS-1:0] cfg_q;
   logic                cfg_unused;

   always_ff @(posedge clk) begin
      if (capture) cfg_q <= cfg_word;
   end

   // protection and reserved bits are decoded elsewhere
   assign cfg_unused = ^cfg_q;

   always_comb begin
      dec.osc    = osc_mode_e'(cfg_q[CFG_OSC_LSB +: 2]);
      dec.wdt_en = cfg_q[CFG_WDT_BIT];
      dec.bor_en = cfg_q[CFG_BOR_BIT];
      // brown-out enable forces the power-up delay
      dec.dly_en = ~cfg_q[CFG_DLY_N_BIT] | cfg_q[CFG_BOR_BIT];
   end

endmodule

// File: rtl/pwrup_seq_timer.sv
module pwrup_seq_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic clr,
   input  logic step,
   output logic done
);

   generate
      if (LIMIT == 1) begin : g_single
         logic clk_unused;
         assign clk_unused = clk;
         assign done = step & ~clr;
      end else begin : g_count
         localparam int CW = $clog2(LIMIT);
         localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
         logic [CW-1:0] cnt_q;

         assign done = step & ~clr & (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (clr)       cnt_q <= '0;
            else if (step) cnt_q <= done ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
   import pwrup_seq_pkg::*;
(
   input  logic               clk,
   input  logic               por,
   input  logic               bod_trip,
   input  logic               ext_hold,
   input  logic               wdt_bite,
   input  logic               dly_en,
   input  logic               osc_rc,
   input  logic               dly_done,
   input  logic               osc_done,
   output logic               in_delay,
   output logic               in_osc,
   output logic               core_rst,
   output logic [CAUSE_W-1:0] cause
);

   seq_state_e         state_q, state_d;
   logic [CAUSE_W-1:0] cause_q, cause_d;
   logic               booted_q, booted_d;
   seq_state_e         first_phase, post_delay;

   assign post_delay  = osc_rc ? ST_RUN : ST_OSC;
   assign first_phase = dly_en ? ST_DELAY : post_delay;

   always_comb begin
      state_d  = state_q;
      cause_d  = cause_q;
      booted_d = booted_q;
      if (bod_trip) begin
         state_d  = ST_BROWN;
         cause_d  = CAUSE_BOR_V;
         booted_d = 1'b0;
      end else if (ext_hold) begin
         state_d = ST_PIN;
         cause_d = CAUSE_EXT_V;
      end else begin
         unique case (state_q)
            ST_HOLD, ST_BROWN: state_d = first_phase;
            ST_PIN:            state_d = booted_q ? ST_RUN : first_phase;
            ST_DELAY:          if (dly_done) state_d = post_delay;
            ST_OSC:            if (osc_done) state_d = ST_RUN;
            ST_RUN: begin
               if (wdt_bite) begin
                  state_d = ST_WDOG;
                  cause_d = CAUSE_WDT_V;
               end
            end
            ST_WDOG:           state_d = ST_RUN;
            default:           state_d = ST_HOLD;
         endcase
      end
      if (state_d == ST_RUN) booted_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (por) begin
         state_q  <= ST_HOLD;
         cause_q  <= CAUSE_POR_V;
         booted_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         cause_q  <= cause_d;
         booted_q <= booted_d;
      end
   end

   assign in_delay = (state_q == ST_DELAY);
   assign in_osc   = (state_q == ST_OSC);
   assign core_rst = (state_q != ST_RUN);
   assign cause    = cause_q;

endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
   import pwrup_seq_pkg::*;
#(
   parameter int CFG_BITS   = 14,
   parameter int PWRT_TICKS = 72,
   parameter int OST_CYCLES = 1024
) (
   input  logic                clk,
   input  logic                por_pulse,
   input  logic [CFG_BITS-1:0] cfg_word,
   input  logic                bod_level,
   input  logic                ext_rst_n,
   input  logic                rc_tick,
   input  logic                wdt_timeout,
   output logic                core_rst,
   output logic                wdt_en,
   output logic [1:0]          osc_mode,
   output logic [CAUSE_W-1:0]  rst_cause
);

   generate
      if (CFG_BITS <= CFG_BOR_BIT) begin : g_bad_cfg
         $error("CFG_BITS too narrow for the decoded fields");
      end
      if (PWRT_TICKS < 1) begin : g_bad_pwrt
         $error("PWRT_TICKS must be at least 1");
      end
      if (OST_CYCLES < 1) begin : g_bad_ost
         $error("OST_CYCLES must be at least 1");
      end
   endgenerate

   cfg_dec_t dec;
   logic     in_delay, in_osc, dly_done, osc_done;

   pwrup_cfg_latch #(.CFG_BITS(CFG_BITS)) u_cfg (
      .clk      (clk),
      .capture  (por_pulse),
      .cfg_word (cfg_word),
      .dec      (dec)
   );

   pwrup_seq_timer #(.LIMIT(PWRT_TICKS)) u_dly_tmr (
      .clk  (clk),
      .clr  (~in_delay),
      .step (rc_tick),
      .done (dly_done)
   );

   pwrup_seq_timer #(.LIMIT(OST_CYCLES)) u_osc_tmr (
      .clk  (clk),
      .clr  (~in_osc),
      .step (1'b1),
      .done (osc_done)
   );

   pwrup_seq_fsm u_fsm (
      .clk      (clk),
      .por      (por_pulse),
      .bod_trip (dec.bor_en & bod_level),
      .ext_hold (~ext_rst_n),
      .wdt_bite (dec.wdt_en & wdt_timeout),
      .dly_en   (dec.dly_en),
      .osc_rc   (dec.osc == OSC_RC),
      .dly_done (dly_done),
      .osc_done (osc_done),
      .in_delay (in_delay),
      .in_osc   (in_osc),
      .core_rst (core_rst),
      .cause    (rst_cause)
   );

   assign wdt_en   = dec.wdt_en;
   assign osc_mode = dec.osc;

endmodule

// File: rtl/pwrup_rst_seq_chk.sv
module pwrup_rst_seq_chk (
   input logic       clk,
   input logic       por_pulse,
   input logic       bor_cfg,
   input logic       bod_level,
   input logic       ext_rst_n,
   input logic       wdt_timeout,
   input logic       core_rst,
   input logic       wdt_en,
   input logic [3:0] rst_cause
);

   logic bor_on;

   always_ff @(posedge clk) begin
      if (por_pulse) bor_on <= bor_cfg;
   end

   assert_por_hold_R1: assert property (@(posedge clk)
      por_pulse |=> (core_rst && rst_cause == 4'b0001));

   assert_wdt_cfg_fixed_R2: assert property (@(posedge clk) disable iff (por_pulse)
      !$past(por_pulse) |-> $stable(wdt_en));

   assert_brownout_R7: assert property (@(posedge clk) disable iff (por_pulse)
      (bor_on && bod_level) |=> (core_rst && rst_cause == 4'b0010));

   assert_pin_reset_R8: assert property (@(posedge clk) disable iff (por_pulse)
      (!ext_rst_n && !(bor_on && bod_level)) |=> (core_rst && rst_cause == 4'b0100));

   assert_release_needs_pin_R8: assert property (@(posedge clk) disable iff (por_pulse)
      $fell(core_rst) |-> $past(ext_rst_n));

   assert_wdt_bite_R9: assert property (@(posedge clk) disable iff (por_pulse)
      (wdt_en && !core_rst && wdt_timeout && ext_rst_n && !(bor_on && bod_level))
      |=> (core_rst && rst_cause == 4'b1000));

   assert_wdt_ignored_R9: assert property (@(posedge clk) disable iff (por_pulse)
      (!wdt_en && !core_rst && ext_rst_n && !(bor_on && bod_level)) |=> !core_rst);

   assert_cause_onehot_R10: assert property (@(posedge clk) disable iff (por_pulse)
      $countones(rst_cause) == 1);

endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk u_chk (
   .clk         (clk),
   .por_pulse   (por_pulse),
   .bor_cfg     (cfg_word[pwrup_seq_pkg::CFG_BOR_BIT]),
   .bod_level   (bod_level),
   .ext_rst_n   (ext_rst_n),
   .wdt_timeout (wdt_timeout),
   .core_rst    (core_rst),
   .wdt_en      (wdt_en),
   .rst_cause   (rst_cause)
);

// File: tb/pwrup_rst_seq_tb.sv
module pwrup_rst_seq_tb;

   localparam int P    = 6;
   localparam int O    = 20;
   localparam int TDIV = 4;
   localparam int LO   = (P - 1) * TDIV + 2 + O;
   localparam int HI   = P * TDIV + 1 + O;

   logic        clk = 1'b0;
   logic        por_pulse = 1'b1;
   logic [13:0] cfg_word = 14'h3FB5;
   logic        bod_level = 1'b0;
   logic        ext_rst_n = 1'b1;
   logic        rc_tick = 1'b0;
   logic        wdt_timeout = 1'b0;
   logic        core_rst, wdt_en;
   logic [1:0]  osc_mode;
   logic [3:0]  rst_cause;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   pwrup_rst_seq #(.CFG_BITS(14), .PWRT_TICKS(P), .OST_CYCLES(O)) u_dut (
      .clk(clk), .por_pulse(por_pulse), .cfg_word(cfg_word), .bod_level(bod_level),
      .ext_rst_n(ext_rst_n), .rc_tick(rc_tick), .wdt_timeout(wdt_timeout),
      .core_rst(core_rst), .wdt_en(wdt_en), .osc_mode(osc_mode), .rst_cause(rst_cause)
   );

   // slow tick strobe, one cycle in every TDIV
   int tdiv = 0;
   always @(negedge clk) begin
      tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
      rc_tick <= (tdiv == TDIV - 1);
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input string what, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
      end
   endtask

   // behavioural reference model
   localparam int M_HOLD = 0, M_BOR = 1, M_EXT = 2, M_DLY = 3, M_OSC = 4, M_RUN = 5, M_WDG = 6;
   int          ms = M_HOLD;
   int          mcnt = 0;
   logic [13:0] mcfg = '0;
   int          mcause = 1;
   bit          mdone = 0;
   bit          mvalid = 0;

   always @(posedge clk) begin
      bit dly, rc;
      if (por_pulse) begin
         ms = M_HOLD; mcfg = cfg_word; mcause = 1; mcnt = 0; mdone = 0;
      end else begin
         dly = !mcfg[3] || mcfg[6];
         rc  = (mcfg[1:0] == 2'b11);
         if (mcfg[6] && bod_level) begin
            ms = M_BOR; mcause = 2; mcnt = 0; mdone = 0;
         end else if (!ext_rst_n) begin
            ms = M_EXT; mcause = 4; mcnt = 0;
         end else begin
            case (ms)
               M_HOLD, M_BOR: ms = dly ? M_DLY : (rc ? M_RUN : M_OSC);
               M_EXT: if (mdone) ms = M_RUN; else ms = dly ? M_DLY : (rc ? M_RUN : M_OSC);
               M_DLY: if (rc_tick) begin
                  mcnt++;
                  if (mcnt == P) begin mcnt = 0; ms = rc ? M_RUN : M_OSC; end
               end
               M_OSC: begin
                  mcnt++;
                  if (mcnt == O) begin mcnt = 0; ms = M_RUN; end
               end
               M_RUN: if (mcfg[2] && wdt_timeout) begin ms = M_WDG; mcause = 8; end
               default: ms = M_RUN;
            endcase
         end
         if (ms == M_RUN) mdone = 1;
      end
      mvalid = 1;
   end

   always @(negedge clk) begin
      if (mvalid) begin
         chk(cur_req, "core_rst vs model", int'(core_rst), int'(ms != M_RUN));
         chk("R10", "rst_cause vs model", int'(rst_cause), mcause);
         chk("R2", "wdt_en vs model", int'(wdt_en), int'(mcfg[2]));
         chk("R3", "osc_mode vs model", int'(osc_mode), int'(mcfg[1:0]));
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rel(output int n);
      n = 0;
      while (core_rst && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      int n;
      // A: crystal XT, watchdog on, delay on, brown-out off
      cur_req = "R1";
      cyc(3);
      chk("R1", "core_rst during power-on", int'(core_rst), 1);
      chk("R10", "cause after power-on", int'(rst_cause), 1);
      chk("R2", "wdt_en from bit 2", int'(wdt_en), 1);
      chk("R3", "osc_mode XT", int'(osc_mode), 1);
      cur_req = "R4";
      por_pulse = 1'b0;
      wait_rel(n);
      chk_rng("R4 R6", "cycles to release with delay and settle", n, LO, HI);
      cyc(3);

      // B: watchdog bite
      cur_req = "R9";
      wdt_timeout = 1'b1;
      cyc(1);
      wdt_timeout = 1'b0;
      chk("R9", "core_rst on bite", int'(core_rst), 1);
      chk("R9", "cause watchdog", int'(rst_cause), 8);
      cyc(1);
      chk("R9", "core_rst one cycle only", int'(core_rst), 0);

      // C: external pin after boot
      cur_req = "R8";
      ext_rst_n = 1'b0;
      cyc(1);
      chk("R8", "core_rst on pin", int'(core_rst), 1);
      chk("R8", "cause external", int'(rst_cause), 4);
      cyc(3);
      ext_rst_n = 1'b1;
      cyc(1);
      chk("R8", "restart one cycle after release", int'(core_rst), 0);
      cur_req = "R11";
      ext_rst_n = 1'b0;
      wdt_timeout = 1'b1;
      cyc(1);
      chk("R11", "pin beats watchdog", int'(rst_cause), 4);
      wdt_timeout = 1'b0;
      ext_rst_n = 1'b1;
      cyc(2);

      // D: RC, watchdog off, no delay, brown-out off
      cur_req = "R5";
      cfg_word = 14'h3FBB;
      por_pulse = 1'b1;
      cyc(2);
      chk("R3", "osc_mode RC", int'(osc_mode), 3);
      chk("R2", "wdt_en cleared", int'(wdt_en), 0);
      por_pulse = 1'b0;
      wait_rel(n);
      chk("R5 R6", "RC without delay releases in one cycle", n, 1);
      cur_req = "R9";
      wdt_timeout = 1'b1;
      cyc(2);
      wdt_timeout = 1'b0;
      chk("R9", "timeout ignored when disabled", int'(core_rst), 0);
      chk("R9", "cause unchanged", int'(rst_cause), 1);
      cur_req = "R7";
      bod_level = 1'b1;
      cyc(3);
      chk("R7", "brown-out ignored when disabled", int'(core_rst), 0);
      chk("R7", "cause unchanged by ignored brown-out", int'(rst_cause), 1);
      bod_level = 1'b0;

      // E: HS, brown-out on forces delay though bit 3 is 1
      cur_req = "R4";
      cfg_word = 14'h3FFA;
      por_pulse = 1'b1;
      cyc(2);
      por_pulse = 1'b0;
      wait_rel(n);
      chk_rng("R4", "delay forced by brown-out enable", n, LO, HI);
      cyc(2);
      cur_req = "R7";
      bod_level = 1'b1;
      cyc(1);
      chk("R7", "core_rst on brown-out", int'(core_rst), 1);
      chk("R7", "cause brown-out", int'(rst_cause), 2);
      cur_req = "R11";
      ext_rst_n = 1'b0;
      cyc(2);
      chk("R11", "brown-out beats pin", int'(rst_cause), 2);
      ext_rst_n = 1'b1;
      cyc(2);
      cur_req = "R7";
      bod_level = 1'b0;
      wait_rel(n);
      chk_rng("R7", "full sequence after brown-out", n, LO, HI);
      cur_req = "R8";
      bod_level = 1'b1;
      cyc(1);
      bod_level = 1'b0;
      cyc(5);
      ext_rst_n = 1'b0;
      cyc(2);
      ext_rst_n = 1'b1;
      wait_rel(n);
      chk_rng("R8", "pin during boot restarts sequence", n, LO, HI);

      // F: power-on together with pin
      cur_req = "R11";
      ext_rst_n = 1'b0;
      por_pulse = 1'b1;
      cyc(2);
      chk("R11", "power-on beats pin", int'(rst_cause), 1);
      chk("R1", "core_rst held", int'(core_rst), 1);
      cur_req = "R8";
      por_pulse = 1'b0;
      cyc(1);
      chk("R8", "pin cause after power-on ends", int'(rst_cause), 4);
      ext_rst_n = 1'b1;
      wait_rel(n);
      chk_rng("R8", "boot after pin released", n, LO, HI);
      cyc(2);
      finish_run();
   end

endmodule